// File: doc/BRIEF.md
# Serial Receive Character Queue with Overrun Capture

This block sits behind the deserializer of one serial channel, or behind transmit loopback. Each assembled character arrives with a one-cycle valid strobe. It goes into a shallow first-in first-out queue, and a bus read strobe drains the queue one character at a time, oldest first. Status outputs show whether data is waiting and whether the queue is full. A masked interrupt request tells the host that fresh data has arrived.

When the queue is full, an arriving character is not dropped. It is parked in a single holding stage. A second arrival while the stage is occupied replaces the parked character and raises a sticky overrun flag. As soon as a read opens a slot, the parked character moves into the queue behind the older entries. A receiver enable input gates arrivals. Turning the receiver on discards all buffered characters, so the ready flag starts low.

Top module: `uart_rx_fifo`

## Requirements
- R1: While rst_ni is low and on the first cycle after its release, rd_data_o, rx_rdy_o, ffull_o, overrun_o and irq_o are all 0.
- R2: A character strobed with char_vld_i while rx_en_i is high and the queue has room is stored. rx_rdy_o is 1 from the next cycle while at least one character is queued. Reads return characters in arrival order.
- R3: ffull_o is 1 exactly when the queue holds DEPTH characters (3 by default), and the queue never holds more than that.
- R4: A character that arrives while the queue is full is parked in the holding stage. An arrival while the stage is already occupied replaces the parked character and sets overrun_o, which stays 1 until cleared.
- R5: When a read frees a slot and a character is parked, that character enters the queue on the following cycle, behind the existing entries.
- R6: A read strobe while the queue is empty loads 0 into rd_data_o.
- R7: rd_data_o takes the read result on the clock edge that samples rd_i and holds it until the next read.
- R8: A pending flag is set on every write into the queue and cleared by a read, and the write wins when both happen in one cycle. irq_o equals the pending flag ANDed with irq_mask_i.
- R9: A one-cycle pulse on err_clr_i clears overrun_o, unless an overwrite happens in the same cycle.
- R10: While rx_en_i is low, arriving characters are ignored. On the first cycle rx_en_i is high after being low, the queue, the holding stage and the pending flag are emptied, so rx_rdy_o drops. overrun_o is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_vld_i | input | 1 | One-cycle strobe: a received character is present |
| char_data_i | input | DW | Received character |
| rd_i | input | 1 | Read strobe for the receive data register |
| rx_en_i | input | 1 | Receiver enable level |
| err_clr_i | input | 1 | Clear the overrun flag |
| irq_mask_i | input | 1 | Receive interrupt mask, 1 enables the request |
| rd_data_o | output | DW | Last read result |
| rx_rdy_o | output | 1 | At least one character queued |
| ffull_o | output | 1 | Queue full |
| overrun_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with its defaults, DW of 8 and DEPTH of 3. With such a shallow queue, every boundary is reached within a few strobes: full, parked, overwritten, drained back to empty and read while empty. It also hits the case of a read and an arrival in the same cycle while the queue is full, where the arrival must be parked and then moved in, not lost. A reference model in the bench tracks the queue, the holding stage, the pending flag and overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  // which source feeds the queue write port this cycle
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_HOLD = 2'd1,
    WR_LINE = 2'd2
  } wr_src_e;
endpackage

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic                          wr_i,
  input  logic [DW-1:0]                 wr_data_i,
  input  logic                          rd_i,
  output logic [DW-1:0]                 head_o,
  output logic                          full_o,
  output logic                          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_wr   = wr_i && !full_o && !flush_i;
  assign do_rd   = rd_i && !empty_o && !flush_i;
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[i] <= '0;
      else if (do_wr && wr_ptr_q == AW'(i))      mem_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_rd) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3: occupancy bound
  always_comb a_r3_cnt_bound: assert (!rst_ni || cnt_q <= CW'(DEPTH));

  a_r2_push_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_wr && !do_rd) |=> cnt_q == $past(cnt_q) + CW'(1));

  a_r3_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_i && !flush_i) |=> full_o);
endmodule

// File: rtl/rx_hold_stage.sv
module rx_hold_stage #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          drain_i,
  input  logic          clr_err_i,
  output logic          vld_o,
  output logic [DW-1:0] data_o,
  output logic          overrun_o
);
  logic overwrite;

  // replacing a parked char that is not leaving this cycle loses it
  assign overwrite = load_i && vld_o && !drain_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else if (flush_i) begin
      vld_o  <= 1'b0;
    end else if (load_i) begin
      vld_o  <= 1'b1;
      data_o <= load_data_i;
    end else if (drain_i) begin
      vld_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        overrun_o <= 1'b0;
    else if (overwrite) overrun_o <= 1'b1;
    else if (clr_err_i) overrun_o <= 1'b0;
  end

  a_r4_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !clr_err_i) |=> overrun_o);

  a_r4_overwrite_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overwrite |=> overrun_o && vld_o);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_i && !overwrite) |=> !overrun_o);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          char_vld_i,
  input  logic [DW-1:0] char_data_i,
  input  logic          rd_i,
  input  logic          rx_en_i,
  input  logic          err_clr_i,
  input  logic          irq_mask_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rx_rdy_o,
  output logic          ffull_o,
  output logic          overrun_o,
  output logic          irq_o
);
  logic          en_q, flush, accept;
  logic          fifo_full, fifo_empty, fifo_wr;
  logic [DW-1:0] fifo_head, fifo_wdata;
  logic          hold_vld, hold_load;
  logic [DW-1:0] hold_data;
  logic          pend_q;
  wr_src_e       src;

  assign flush  = rx_en_i && !en_q;
  assign accept = char_vld_i && rx_en_i && !flush;

  // parked char is older than a fresh arrival, so it takes the slot first
  always_comb begin
    if (flush)                        src = WR_NONE;
    else if (hold_vld && !fifo_full)  src = WR_HOLD;
    else if (accept && !fifo_full)    src = WR_LINE;
    else                              src = WR_NONE;
  end

  assign fifo_wr    = (src != WR_NONE);
  assign fifo_wdata = (src == WR_HOLD) ? hold_data : char_data_i;
  assign hold_load  = accept && (src != WR_LINE);

  rx_char_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .wr_i      (fifo_wr),
    .wr_data_i (fifo_wdata),
    .rd_i      (rd_i),
    .head_o    (fifo_head),
    .full_o    (fifo_full),
    .empty_o   (fifo_empty)
  );

  rx_hold_stage #(.DW(DW)) i_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .load_i      (hold_load),
    .load_data_i (char_data_i),
    .drain_i     (src == WR_HOLD),
    .clr_err_i   (err_clr_i),
    .vld_o       (hold_vld),
    .data_o      (hold_data),
    .overrun_o   (overrun_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      rd_data_o <= '0;
      pend_q    <= 1'b0;
    end else begin
      en_q <= rx_en_i;
      if (rd_i) rd_data_o <= fifo_empty ? '0 : fifo_head;
      if (flush)        pend_q <= 1'b0;
      else if (fifo_wr) pend_q <= 1'b1;
      else if (rd_i)    pend_q <= 1'b0;
    end
  end

  assign rx_rdy_o = !fifo_empty;
  assign ffull_o  = fifo_full;
  assign irq_o    = pend_q && irq_mask_i;

  a_r6_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rx_rdy_o) |=> rd_data_o == '0);

  a_r7_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !fifo_wr && !flush) |=> !irq_o);

  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !rx_rdy_o && !irq_o);

  a_r10_disabled_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !rx_rdy_o) |=> !rx_rdy_o);
endmodule

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          char_vld_i = 1'b0;
  logic [DW-1:0] char_data_i = '0;
  logic          rd_i = 1'b0;
  logic          rx_en_i = 1'b0;
  logic          err_clr_i = 1'b0;
  logic          irq_mask_i = 1'b0;
  logic [DW-1:0] rd_data_o;
  logic          rx_rdy_o, ffull_o, overrun_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  uart_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) i_uart_rx_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .char_vld_i(char_vld_i), .char_data_i(char_data_i),
    .rd_i(rd_i), .rx_en_i(rx_en_i), .err_clr_i(err_clr_i), .irq_mask_i(irq_mask_i),
    .rd_data_o(rd_data_o), .rx_rdy_o(rx_rdy_o), .ffull_o(ffull_o),
    .overrun_o(overrun_o), .irq_o(irq_o)
  );

  // reference model
  logic [DW-1:0] m_q[$];
  logic          m_hold_v = 1'b0;
  logic [DW-1:0] m_hold = '0;
  logic          m_ovr = 1'b0;
  logic          m_pend = 1'b0;

  // scoreboard of expected read results
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          mon_arm = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) mon_arm <= rd_i;

  always @(negedge clk) begin
    if (mon_arm) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R7 unexpected read: actual %0h expected none", rd_data_o);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "read data", int'(rd_data_o), int'(e));
      end
    end
  end

  task automatic status(input string req);
    check(req, "rx_rdy", int'(rx_rdy_o), int'(m_q.size() > 0));
    check(req, "ffull", int'(ffull_o), int'(m_q.size() == DEPTH));
    check(req, "overrun", int'(overrun_o), int'(m_ovr));
    check(req, "irq", int'(irq_o), int'(m_pend && irq_mask_i));
  endtask

  // model updates happen after the design has had its cycles
  task automatic model_push(input logic [DW-1:0] c);
    if (!rx_en_i) return;
    if (m_q.size() < DEPTH) begin
      m_q.push_back(c);
      m_pend = 1'b1;
    end else begin
      if (m_hold_v) m_ovr = 1'b1;
      m_hold_v = 1'b1;
      m_hold = c;
    end
  endtask

  task automatic model_read(input string req);
    if (m_q.size() > 0) exp_q.push_back(m_q.pop_front());
    else                exp_q.push_back('0);
    tag_q.push_back(req);
    m_pend = 1'b0;
  endtask

  task automatic model_move();
    if (m_hold_v && m_q.size() < DEPTH) begin
      m_q.push_back(m_hold);
      m_hold_v = 1'b0;
      m_pend = 1'b1;
    end
  endtask

  task automatic push_char(input logic [DW-1:0] c);
    @(negedge clk);
    char_vld_i = 1'b1; char_data_i = c;
    model_push(c);
    @(negedge clk);
    char_vld_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_char(input string req);
    @(negedge clk);
    rd_i = 1'b1;
    model_read(req);
    @(negedge clk);
    rd_i = 1'b0;
    @(negedge clk);
    model_move();
  endtask

  task automatic read_and_push(input logic [DW-1:0] c, input string req);
    @(negedge clk);
    rd_i = 1'b1; char_vld_i = 1'b1; char_data_i = c;
    model_read(req);
    model_push(c);
    @(negedge clk);
    rd_i = 1'b0; char_vld_i = 1'b0;
    @(negedge clk);
    model_move();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1 reset values
    repeat (3) @(negedge clk);
    check("R1", "rd_data in reset", int'(rd_data_o), 0);
    status("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "rd_data after reset", int'(rd_data_o), 0);
    status("R1");
    rx_en_i = 1'b1; irq_mask_i = 1'b1;
    repeat (2) @(negedge clk);

    // R6 read while empty
    read_char("R6");
    status("R6");

    // R2 ordering, R3 full
    push_char(8'hA1); status("R2");
    push_char(8'hA2); status("R2");
    push_char(8'hA3); status("R3");

    // R4 park then overwrite
    push_char(8'hA4); status("R4");
    push_char(8'hA5); status("R4");

    // R5 parked char moves in after a read; R7 order
    read_char("R5"); status("R5");
    read_char("R7"); status("R7");
    read_char("R7");
    read_char("R5"); status("R5");
    read_char("R6"); status("R6");

    // R9 clear overrun
    @(negedge clk); err_clr_i = 1'b1; m_ovr = 1'b0;
    @(negedge clk); err_clr_i = 1'b0;
    status("R9");

    // R8 masking and read clear
    irq_mask_i = 1'b0;
    push_char(8'h5C); status("R8");
    irq_mask_i = 1'b1;
    @(negedge clk); status("R8");
    read_char("R8"); status("R8");

    // R5 read and arrival in the same cycle while full
    push_char(8'h11); push_char(8'h22); push_char(8'h33);
    read_and_push(8'h44, "R5"); status("R5");
    for (int k = 0; k < 4; k++) read_char("R5");
    status("R5");

    // R10 disabled arrivals ignored, enable flushes
    push_char(8'h61); push_char(8'h62);
    rx_en_i = 1'b0;
    push_char(8'h63); status("R10");
    @(negedge clk); rx_en_i = 1'b1;
    m_q.delete(); m_hold_v = 1'b0; m_pend = 1'b0;
    @(negedge clk); status("R10");
    read_char("R10");

    // sweep of patterns through fill levels
    for (int p = 0; p < 4; p++) begin
      for (int j = 0; j <= p; j++) push_char(8'(8'h80 + p * 16 + j));
      status("R2");
      for (int j = 0; j <= p; j++) read_char("R2");
      status("R2");
    end

    repeat (3) @(negedge clk);
    check("R7", "scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule